// File: doc/BRIEF.md
# Serial Flash Page-Program Engine

This block is the device-side logic of a serial NOR flash that takes a page-program command from a SPI host. The host drives the serial clock, chip select and serial input. They are sampled on the system clock `clk`, and the serial input is taken on rising serial-clock edges. The block decodes a write-enable opcode and a program opcode. It collects a three-byte address and holds up to one page of data in a 256-byte buffer, together with a 256-bit mask of the offsets that were received.

When chip select rises cleanly at the end of a valid program frame, the block starts a timed program operation. During that operation it walks the page once and writes each received byte into a byte-wide array port. Each written byte is the old contents ANDed with the new data, so bits can only change from 1 to 0. The write-in-progress and write-enable flags are brought out as status pins. A 3-bit block-protect input fences off the top of the array.

Top module: `spi_page_prog`

## Requirements
- R1: After reset `wip` and `wel` are 0 and `arr_we` is 0.
- R2: A frame holding only the single byte 0x06 sets `wel` to 1.
- R3: A program frame (opcode 0x02) sent while `wel` is 0 is ignored: `wip` stays 0 and the array is not written.
- R4: A program frame is the opcode, then three address bytes sent most significant first, then data bytes, all with each byte sent MSB first. SI is sampled on rising SCK edges. It works with SCK idling low (mode 0) and idling high (mode 3).
- R5: Data bytes fill the page starting at address bits 7:0 and wrap from offset 0xFF to offset 0x00 of the same page.
- R6: When more than 256 data bytes arrive, only the last 256 are programmed.
- R7: Only the offsets that received data are written; all other bytes of the page are left untouched.
- R8: If chip select rises anywhere other than right after the 8th bit of a data byte, the program is not executed, the array is not written, and `wel` keeps its value.
- R9: `wip` goes to 1 two clock cycles after chip select rises on an accepted program. It stays at 1 for max(PROG_CYCLES, 256) cycles, which is 300 by default. All array writes fall inside that window, go to one page, and come in ascending offset order.
- R10: `wel` is 0 from the first cycle in which `wip` is 1.
- R11: For `bp` = k with k nonzero, the top (4 MiB >> (7 - k)) bytes of the 22-bit array space are protected. A program aimed there is rejected, and `wel` keeps its value.
- R12: Each written byte equals the stored byte ANDed with the new data.
- R13: A frame that begins while `wip` is 1 is ignored entirely: write-enable has no effect and a program writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data from host |
| bp | input | 3 | Block-protect level |
| wip | output | 1 | Program operation in progress |
| wel | output | 1 | Write-enable latch |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | MEM_AW | Array byte address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data at `arr_addr` |

## Verification
The hardest case to reach is a frame that opens while a program is still running and whose chip-select window outlasts that program. The block must ignore that frame to its end, even after `wip` drops. The stimulus starts a one-byte program and, within a few cycles, sends a write-enable frame and then a long program frame, so that `wip` falls midway through the second frame. A 300-byte frame that laps its starting offset, and chip-select rises three bits into a data byte, make up the other hard cases.

// File: rtl/spi_page_prog.sv
module spi_page_prog #(
  parameter int          MEM_AW      = 22,
  parameter int          PROG_CYCLES = 300,
  parameter logic [7:0]  OP_WREN     = 8'h06,
  parameter logic [7:0]  OP_PROG     = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic [2:0]        bp,
  output logic              wip,
  output logic              wel,
  output logic              arr_we,
  output logic [MEM_AW-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  input  logic [7:0]        arr_rdata
);

  localparam int PAGE = 256;
  localparam int DUR  = (PROG_CYCLES > PAGE) ? PROG_CYCLES : PAGE;
  localparam int TW   = $clog2(DUR + 1);
  localparam int PGW  = MEM_AW - 8;
  localparam logic [MEM_AW:0] FULL = {1'b1, {MEM_AW{1'b0}}};

  logic              sck_q, sck_qq, cs_q, cs_qq, si_q, active;
  logic [2:0]        bitcnt, bytecnt;
  logic [6:0]        sh;
  logic [7:0]        opcode, ptr;
  logic [MEM_AW-1:0] addr;
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   mask;
  logic [PGW-1:0]    pg;
  logic [TW-1:0]     tcnt;
  logic [MEM_AW:0]   psize;

  wire       sck_rise = sck_q & ~sck_qq & ~cs_q & active;
  wire       cs_rise  = cs_q & ~cs_qq;
  wire       cs_fall  = ~cs_q & cs_qq;
  wire       byte_end = sck_rise & (bitcnt == 3'd7);
  wire [7:0] nb       = {sh, si_q};
  wire       data_byte = byte_end & (bytecnt >= 3'd4) & (opcode == OP_PROG);

  assign psize = FULL >> (3'd7 - bp);
  wire prot = (bp != 3'd0) && ({1'b0, addr} >= FULL - psize);

  wire go_prog = cs_rise & active & ~wip & wel & (opcode == OP_PROG) &
                 (bytecnt == 3'd5) & (bitcnt == 3'd0) & ~prot;
  wire go_wren = cs_rise & active & ~wip & (opcode == OP_WREN) &
                 (bytecnt == 3'd1) & (bitcnt == 3'd0);

  wire [7:0] ofs    = tcnt[7:0];
  wire       commit = wip & (tcnt < TW'(PAGE));

  assign arr_we    = commit & mask[ofs];
  assign arr_addr  = {pg, ofs};
  assign arr_wdata = arr_rdata & pbuf[ofs];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      sck_qq  <= 1'b0;
      cs_q    <= 1'b1;
      cs_qq   <= 1'b1;
      si_q    <= 1'b0;
      active  <= 1'b0;
      bitcnt  <= '0;
      bytecnt <= '0;
      sh      <= '0;
      opcode  <= '0;
      addr    <= '0;
      ptr     <= '0;
      mask    <= '0;
    end else begin
      sck_q  <= sck;
      sck_qq <= sck_q;
      cs_q   <= cs_n;
      cs_qq  <= cs_q;
      si_q   <= si;
      if (cs_fall) active <= ~wip;
      if (cs_fall && !wip) mask <= '0;
      if (cs_q) begin
        bitcnt  <= '0;
        bytecnt <= '0;
      end else if (sck_rise) begin
        bitcnt <= bitcnt + 3'd1;
        sh     <= {sh[5:0], si_q};
        if (bitcnt == 3'd7 && bytecnt != 3'd5) bytecnt <= bytecnt + 3'd1;
      end
      if (byte_end) begin
        case (bytecnt)
          3'd0:    opcode <= nb;
          3'd1,
          3'd2:    addr <= {addr[MEM_AW-9:0], nb};
          3'd3: begin
            addr <= {addr[MEM_AW-9:0], nb};
            ptr  <= nb;
          end
          default: ;
        endcase
      end
      if (data_byte) begin
        mask[ptr] <= 1'b1;
        ptr       <= ptr + 8'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (data_byte) pbuf[ptr] <= nb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip  <= 1'b0;
      wel  <= 1'b0;
      tcnt <= '0;
      pg   <= '0;
    end else begin
      if (go_prog) begin
        wip  <= 1'b1;
        wel  <= 1'b0;
        tcnt <= '0;
        pg   <= addr[MEM_AW-1:8];
      end else if (wip) begin
        if (tcnt == TW'(DUR - 1)) wip <= 1'b0;
        else                      tcnt <= tcnt + 1'b1;
      end
      if (go_wren) wel <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_page_prog_chk.sv
module spi_page_prog_chk #(
  parameter int MEM_AW = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wip,
  input logic              wel,
  input logic              arr_we,
  input logic [MEM_AW-1:0] arr_addr,
  input logic [7:0]        arr_wdata,
  input logic [7:0]        arr_rdata
);

  p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));

  p_start_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_n));

  p_wel_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> !wel);

  p_write_in_wip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> wip);

  p_ascending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr[7:0] > $past(arr_addr[7:0])));

  p_one_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |-> (arr_addr[MEM_AW-1:8] == $past(arr_addr[MEM_AW-1:8])));

  p_clear_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> ((arr_wdata & ~arr_rdata) == 8'h00));

  p_wren_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(wip));

endmodule

bind spi_page_prog spi_page_prog_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wip(wip), .wel(wel),
  .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
);

// File: tb/test_spi_page_prog.sv
module test_spi_page_prog;
  localparam int CLK_P   = 10;
  localparam int AW      = 22;
  localparam int EXP_DUR = 300;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic [2:0] bp = 3'd0;
  logic wip, wel, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata, arr_rdata = 8'hFF;

  spi_page_prog i_spi_page_prog (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .bp(bp),
    .wip(wip), .wel(wel), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct { logic [AW-1:0] a; logic [7:0] d; string tag; } item_t;
  item_t q[$];
  logic [7:0] dmem [int];
  logic [7:0] emem [int];
  int n_chk = 0, n_fail = 0;
  bit mode3 = 0, wel_m = 0, busy_m = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_d(input logic [AW-1:0] a);
    return dmem.exists(int'(a)) ? dmem[int'(a)] : 8'hFF;
  endfunction
  function automatic logic [7:0] rd_e(input logic [AW-1:0] a);
    return emem.exists(int'(a)) ? emem[int'(a)] : 8'hFF;
  endfunction
  function automatic bit is_prot(input logic [23:0] a, input logic [2:0] b);
    logic [AW:0] full, ps;
    full = {1'b1, {AW{1'b0}}};
    ps = full >> (3'd7 - b);
    return (b != 3'd0) && ({1'b0, a[AW-1:0]} >= full - ps);
  endfunction

  always @(posedge clk) if (arr_we) dmem[int'(arr_addr)] = arr_wdata;

  always @(negedge clk) begin
    arr_rdata = rd_d(arr_addr);
    #1;
    if (rst_n && arr_we) begin
      if (q.size() == 0) chk(0, "unexpected write R7", {10'd0, arr_addr}, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk(arr_addr == it.a, it.tag, {10'd0, arr_addr}, {10'd0, it.a});
        chk(arr_wdata == it.d, it.tag, {24'd0, arr_wdata}, {24'd0, it.d});
      end
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic send_bit(input bit b);
    if (mode3) sck = 1'b0;
    si = b; tick(3); sck = 1'b1; tick(3);
    if (!mode3) sck = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask
  task automatic cs_low; sck = mode3; tick(2); cs_n = 1'b0; tick(3); endtask
  task automatic cs_high; tick(2); cs_n = 1'b1; tick(2); endtask

  task automatic wren_frame;
    cs_low; send_byte(8'h06); cs_high;
    if (!busy_m) wel_m = 1;
  endtask

  task automatic pp_frame(input logic [23:0] a, input int n, input logic [7:0] seed,
                          input int extra, input string tag, output bit ok);
    logic [7:0] pb [256];
    bit wm [256];
    logic [7:0] off, d;
    for (int i = 0; i < 256; i++) begin pb[i] = 8'h00; wm[i] = 0; end
    ok = wel_m && !busy_m && !is_prot(a, bp) && n > 0 && extra == 0;
    cs_low;
    send_byte(8'h02);
    send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    off = a[7:0];
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 13);
      pb[off] = d; wm[off] = 1; off = off + 8'd1;
      send_byte(d);
    end
    for (int e = 0; e < extra; e++) send_bit(1'b1);
    if (ok) begin
      for (int o = 0; o < 256; o++) if (wm[o]) begin
        item_t it;
        it.a = {a[AW-1:8], 8'(o)};
        it.d = rd_e(it.a) & pb[o];
        it.tag = tag;
        emem[int'(it.a)] = it.d;
        q.push_back(it);
      end
      wel_m = 0;
    end
    cs_high;
  endtask

  task automatic wait_done(input bit ok, input string tag);
    int cnt;
    if (ok) begin
      chk(wip == 1'b1, {tag, " R9 wip start"}, {31'd0, wip}, 1);
      chk(wel == 1'b0, {tag, " R10 wel"}, {31'd0, wel}, 0);
      cnt = 0;
      while (wip && cnt < 2000) begin cnt++; tick(1); end
      chk(cnt == EXP_DUR, {tag, " R9 duration"}, cnt, EXP_DUR);
      tick(2);
    end else begin
      tick(20);
      chk(wip == 1'b0, {tag, " wip idle"}, {31'd0, wip}, 0);
    end
    chk(q.size() == 0, {tag, " pending writes"}, q.size(), 0);
    chk(wel == wel_m, {tag, " wel"}, {31'd0, wel}, {31'd0, wel_m});
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    bit ok;
    tick(5); rst_n = 1'b1; tick(2);
    chk(wip == 0, "R1 wip", {31'd0, wip}, 0);
    chk(wel == 0, "R1 wel", {31'd0, wel}, 0);
    chk(arr_we == 0, "R1 we", {31'd0, arr_we}, 0);

    pp_frame(24'h001200, 4, 8'h01, 0, "R3", ok); wait_done(ok, "R3");

    wren_frame; chk(wel == 1, "R2 wel set", {31'd0, wel}, 1);

    pp_frame(24'h001200, 256, 8'h11, 0, "R4 full page", ok); wait_done(ok, "R4");

    wren_frame; pp_frame(24'h0023FD, 5, 8'hA0, 0, "R5 wrap", ok); wait_done(ok, "R5");
    wren_frame; pp_frame(24'h003440, 3, 8'h77, 0, "R7 partial", ok); wait_done(ok, "R7");
    wren_frame; pp_frame(24'h004510, 300, 8'h33, 0, "R6 last 256", ok); wait_done(ok, "R6");
    wren_frame; pp_frame(24'h001200, 256, 8'h5C, 0, "R12 and", ok); wait_done(ok, "R12");

    wren_frame; pp_frame(24'h005000, 2, 8'h44, 3, "R8 mid byte", ok); wait_done(ok, "R8");
    pp_frame(24'h005000, 0, 8'h44, 0, "R8 no data", ok); wait_done(ok, "R8");
    pp_frame(24'h005000, 0, 8'h44, 5, "R8 mid data", ok); wait_done(ok, "R8");

    bp = 3'd6; pp_frame(24'h300000, 2, 8'h21, 0, "R11 half", ok); wait_done(ok, "R11");
    bp = 3'd1; pp_frame(24'h3F0000, 2, 8'h21, 0, "R11 top", ok); wait_done(ok, "R11");
    pp_frame(24'h3EFF80, 4, 8'h65, 0, "R11 below", ok); wait_done(ok, "R11");
    bp = 3'd7; wren_frame; pp_frame(24'h000100, 1, 8'h09, 0, "R11 all", ok); wait_done(ok, "R11");
    bp = 3'd0;

    mode3 = 1; wren_frame; pp_frame(24'h006677, 3, 8'hC3, 0, "R4 mode3", ok); wait_done(ok, "R4");
    mode3 = 0;

    wren_frame; pp_frame(24'h007000, 1, 8'h0F, 0, "R13 first", ok);
    chk(wip == 1, "R13 busy", {31'd0, wip}, 1);
    busy_m = 1;
    wren_frame;
    pp_frame(24'h008000, 2, 8'h10, 0, "R13 ignored", ok);
    busy_m = 0;
    for (int i = 0; i < 2000 && wip; i++) tick(1);
    tick(5);
    chk(wel == 0, "R13 wren ignored", {31'd0, wel}, 0);
    chk(q.size() == 0, "R13 writes", q.size(), 0);
    chk(wip == 0, "R13 idle", {31'd0, wip}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule